// File: doc/BRIEF.md
# Hamming ECC Syndrome Checker and Single-Bit Repair

This block takes two 3-byte ECC codes for one 512-byte data block: the code that was kept in the flash spare area, and the code computed again as the data came back. It XORs them byte by byte into a 24-bit syndrome and sorts the outcome into four classes: clean, a single flipped data bit that can be repaired, a fault in the stored ECC bytes alone, or an uncorrectable error. For a repairable error it gives the byte index (0 to 511) and the bit index (0 to 7) of the flipped bit.

When repair is enabled, the block then does a read-modify-write on a data buffer with one cycle of read latency. It reads the byte at the reported index, inverts the single reported bit, writes the byte back and raises a done pulse. ECC generation and page storage are handled elsewhere.

ECC byte k sits in bits [8k+7:8k] of each 24-bit code input. The syndrome bytes are d0 = bits [7:0], d1 = bits [15:8] and d2 = bits [23:16].

Top module: `ecc_bitfix_top`

## Requirements
- R1: A `start_i` pulse sampled on a clock edge gives exactly one cycle of `result_valid_o`, beginning after that edge. When `result_valid_o` is low, `start_i` was low on the previous edge. A syndrome of all zeros reports `status_o` = 0 (clean).
- R2: If the stored code is 24'hFFFFFF and `ignore_blank_i` is 1, the status is 0 whatever the computed code is. If `ignore_blank_i` is 0, such a code is classified like any other code.
- R3: If the syndrome is nonzero and every syndrome byte d satisfies ((d ^ (d >> 1)) & 8'h55) == 8'h55, the status is 1 (repairable). The status encoding is 0 clean, 1 repairable, 2 ECC-only fault, 3 uncorrectable.
- R4: For status 1, `bit_idx_o` is {d2[7], d2[5], d2[3]}, most significant bit first.
- R5: For status 1, `byte_idx_o` is {d2[1], d1[7], d1[5], d1[3], d1[1], d0[7], d0[5], d0[3], d0[1]}, most significant bit first.
- R6: If exactly one of the 24 syndrome bits is set, the status is 2, and the block does not read or write the buffer.
- R7: Any other nonzero syndrome gives status 3, and the block does not read or write the buffer.
- R8: If the status is 1 and `fix_en_i` was 1 with the start pulse, `mem_rd_o` is high for one cycle, one cycle after `result_valid_o`, at the reported byte index. In the next cycle, `mem_wr_o` writes to the same index the read byte XOR (1 << bit index). No other buffer byte changes.
- R9: `fix_done_o` pulses for one cycle, in the cycle after the write.
- R10: If the status is 1 and `fix_en_i` was 0, the buffer is neither read nor written.
- R11: After reset, `result_valid_o`, `mem_rd_o`, `mem_wr_o` and `fix_done_o` are low, and `status_o` is 0.
- R12: For any status other than 1, `byte_idx_o` and `bit_idx_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Strobe: compare the two codes |
| stored_ecc_i | input | 24 | ECC read back from spare storage |
| calc_ecc_i | input | 24 | ECC computed over the data block |
| ignore_blank_i | input | 1 | Treat an all-ones stored code as clean |
| fix_en_i | input | 1 | Repair the buffer after a repairable result |
| result_valid_o | output | 1 | One-cycle result strobe |
| status_o | output | 2 | Result class |
| byte_idx_o | output | 9 | Index of the faulty byte |
| bit_idx_o | output | 3 | Index of the faulty bit |
| mem_rd_o | output | 1 | Buffer read request |
| mem_addr_o | output | 9 | Buffer byte address |
| mem_rdata_i | input | 8 | Buffer read data, one cycle after the request |
| mem_wr_o | output | 1 | Buffer write strobe |
| mem_wdata_o | output | 8 | Repaired byte |
| fix_done_o | output | 1 | Repair finished |

## Verification
The classification result is due one clock after the start edge. The repair read comes one clock later, the write two clocks later and the done pulse three clocks later. The bench records the cycle count at each start edge and at each of these events, and it compares each gap with the latency it expects. It samples only on falling edges. The expected status and indices come from a scoreboard queue filled when each start is driven. After a repair, the bench reads the buffer model directly to confirm that exactly one bit changed and that the bytes next to it did not.

// File: rtl/ecc_bitfix_pkg.sv
package ecc_bitfix_pkg;
  localparam int unsigned BLK_BYTES   = 512;
  localparam int unsigned BYTE_IDX_W  = $clog2(BLK_BYTES);
  localparam int unsigned BIT_IDX_W   = 3;
  localparam int unsigned ECC_W       = 24;
  localparam int unsigned DATA_W      = 8;

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'd0,
    ST_FIXED   = 2'd1,
    ST_ECCONLY = 2'd2,
    ST_FATAL   = 2'd3
  } ecc_status_e;

  // every even/odd bit pair of a syndrome byte must differ
  function automatic logic f_pairs_ok(input logic [7:0] d);
    return ((d ^ (d >> 1)) & 8'h55) == 8'h55;
  endfunction

  function automatic logic f_one_hot(input logic [ECC_W-1:0] s);
    return (s != '0) && ((s & (s - 1'b1)) == '0);
  endfunction

  function automatic logic [BIT_IDX_W-1:0] f_bit_idx(input logic [ECC_W-1:0] s);
    return {s[23], s[21], s[19]};
  endfunction

  function automatic logic [BYTE_IDX_W-1:0] f_byte_idx(input logic [ECC_W-1:0] s);
    return {s[17], s[15], s[13], s[11], s[9], s[7], s[5], s[3], s[1]};
  endfunction

  function automatic ecc_status_e f_classify(input logic [ECC_W-1:0] stored,
                                             input logic [ECC_W-1:0] syn,
                                             input logic             ign_blank);
    if (syn == '0)
      return ST_CLEAN;
    else if (ign_blank && (stored == {ECC_W{1'b1}}))
      return ST_CLEAN;
    else if (f_pairs_ok(syn[7:0]) && f_pairs_ok(syn[15:8]) && f_pairs_ok(syn[23:16]))
      return ST_FIXED;
    else if (f_one_hot(syn))
      return ST_ECCONLY;
    else
      return ST_FATAL;
  endfunction
endpackage

// File: rtl/ecc_syndrome_class.sv
module ecc_syndrome_class
  import ecc_bitfix_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [ECC_W-1:0]      stored_ecc_i,
  input  logic [ECC_W-1:0]      calc_ecc_i,
  input  logic                  ignore_blank_i,
  input  logic                  fix_en_i,
  output logic                  res_valid_o,
  output ecc_status_e           res_status_o,
  output logic [BYTE_IDX_W-1:0] res_byte_o,
  output logic [BIT_IDX_W-1:0]  res_bit_o,
  output logic                  res_fix_o
);
  logic [ECC_W-1:0] syn;
  ecc_status_e      cls;
  logic             cls_fixed;

  assign syn       = stored_ecc_i ^ calc_ecc_i;
  assign cls       = f_classify(stored_ecc_i, syn, ignore_blank_i);
  assign cls_fixed = (cls == ST_FIXED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o  <= 1'b0;
      res_status_o <= ST_CLEAN;
      res_byte_o   <= '0;
      res_bit_o    <= '0;
      res_fix_o    <= 1'b0;
    end else begin
      res_valid_o <= start_i;
      if (start_i) begin
        res_status_o <= cls;
        res_byte_o   <= cls_fixed ? f_byte_idx(syn) : '0;
        res_bit_o    <= cls_fixed ? f_bit_idx(syn)  : '0;
        res_fix_o    <= fix_en_i;
      end
    end
  end

  // R1
  valid_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> res_valid_o);
  // R1
  valid_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !res_valid_o);
  // R12
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_status_o != ST_FIXED) |-> (res_byte_o == '0 && res_bit_o == '0));
endmodule

// File: rtl/ecc_fix_seq.sv
module ecc_fix_seq
  import ecc_bitfix_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  res_valid_i,
  input  ecc_status_e           res_status_i,
  input  logic [BYTE_IDX_W-1:0] res_byte_i,
  input  logic [BIT_IDX_W-1:0]  res_bit_i,
  input  logic                  res_fix_i,
  output logic                  mem_rd_o,
  output logic [BYTE_IDX_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0]     mem_rdata_i,
  output logic                  mem_wr_o,
  output logic [DATA_W-1:0]     mem_wdata_o,
  output logic                  fix_done_o
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_DONE} seq_e;

  seq_e              st;
  logic [DATA_W-1:0] mask_q;
  logic              launch;

  assign launch = (st == S_IDLE) && res_valid_i && res_fix_i && (res_status_i == ST_FIXED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      mem_addr_o <= '0;
      mask_q     <= '0;
    end else begin
      case (st)
        S_IDLE: if (launch) begin
          st         <= S_RD;
          mem_addr_o <= res_byte_i;
          mask_q     <= DATA_W'(1) << res_bit_i;
        end
        S_RD:   st <= S_WR;
        S_WR:   st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd_o    = (st == S_RD);
  assign mem_wr_o    = (st == S_WR);
  assign fix_done_o  = (st == S_DONE);
  assign mem_wdata_o = mem_rdata_i ^ mask_q;

  // R8
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> mem_wr_o);
  // R8
  wr_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (mem_addr_o == $past(mem_addr_o)));
  // R9
  wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> fix_done_o);
  // R10
  no_spurious_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fix_done_o && !mem_rd_o && !mem_wr_o &&
     !(res_valid_i && res_fix_i && res_status_i == ST_FIXED)) |=> !mem_rd_o);
  // R8
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_o, mem_wr_o, fix_done_o}));
endmodule

// File: rtl/ecc_bitfix_top.sv
module ecc_bitfix_top
  import ecc_bitfix_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [23:0] stored_ecc_i,
  input  logic [23:0] calc_ecc_i,
  input  logic        ignore_blank_i,
  input  logic        fix_en_i,
  output logic        result_valid_o,
  output logic [1:0]  status_o,
  output logic [8:0]  byte_idx_o,
  output logic [2:0]  bit_idx_o,
  output logic        mem_rd_o,
  output logic [8:0]  mem_addr_o,
  input  logic [7:0]  mem_rdata_i,
  output logic        mem_wr_o,
  output logic [7:0]  mem_wdata_o,
  output logic        fix_done_o
);
  ecc_status_e           cls_status;
  logic [BYTE_IDX_W-1:0] cls_byte;
  logic [BIT_IDX_W-1:0]  cls_bit;
  logic                  cls_fix;

  ecc_syndrome_class u_class (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .stored_ecc_i   (stored_ecc_i),
    .calc_ecc_i     (calc_ecc_i),
    .ignore_blank_i (ignore_blank_i),
    .fix_en_i       (fix_en_i),
    .res_valid_o    (result_valid_o),
    .res_status_o   (cls_status),
    .res_byte_o     (cls_byte),
    .res_bit_o      (cls_bit),
    .res_fix_o      (cls_fix)
  );

  ecc_fix_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .res_valid_i  (result_valid_o),
    .res_status_i (cls_status),
    .res_byte_i   (cls_byte),
    .res_bit_i    (cls_bit),
    .res_fix_i    (cls_fix),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rdata_i  (mem_rdata_i),
    .mem_wr_o     (mem_wr_o),
    .mem_wdata_o  (mem_wdata_o),
    .fix_done_o   (fix_done_o)
  );

  assign status_o   = cls_status;
  assign byte_idx_o = cls_byte;
  assign bit_idx_o  = cls_bit;

  // R6
  eccfault_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid_o && status_o == 2'd2 && !mem_rd_o && !mem_wr_o && !fix_done_o) |=> !mem_rd_o);
endmodule

// File: tb/sim_ecc_bitfix_top.sv
module sim_ecc_bitfix_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] stored_ecc_i = '0;
  logic [23:0] calc_ecc_i = '0;
  logic        ignore_blank_i = 1'b0;
  logic        fix_en_i = 1'b0;
  logic        result_valid_o;
  logic [1:0]  status_o;
  logic [8:0]  byte_idx_o;
  logic [2:0]  bit_idx_o;
  logic        mem_rd_o;
  logic [8:0]  mem_addr_o;
  logic [7:0]  mem_rdata_i;
  logic        mem_wr_o;
  logic [7:0]  mem_wdata_o;
  logic        fix_done_o;

  always #5 clk = ~clk;

  ecc_bitfix_top u0 (.*);

  typedef struct {
    logic [1:0] st;
    logic [8:0] byt;
    logic [2:0] bt;
    int         cyc;
    string      req;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  mem [512];
  int          cyc = 0;
  int          n_chk = 0, n_err = 0;
  int          n_rd = 0, n_wr = 0, n_done = 0;
  int          rd_cyc = 0, wr_cyc = 0, done_cyc = 0, start_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // buffer model: one cycle read latency
  always @(posedge clk) begin
    if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
    if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_o)   begin n_rd++;   rd_cyc = cyc;   end
      if (mem_wr_o)   begin n_wr++;   wr_cyc = cyc;   end
      if (fix_done_o) begin n_done++; done_cyc = cyc; end
      if (result_valid_o) begin
        if (sb.size() == 0) check(0, "R1", "unexpected valid", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(cyc - e.cyc == 1, "R1", "valid latency", cyc - e.cyc, 1);
          check(status_o == e.st, e.req, "status", status_o, e.st);
          check(byte_idx_o == e.byt, e.req, "byte index", byte_idx_o, e.byt);
          check(bit_idx_o == e.bt, e.req, "bit index", bit_idx_o, e.bt);
        end
      end
    end
  end

  // syndrome for a repairable flip at byte b, bit k
  function automatic logic [23:0] mk_syn(input logic [8:0] b, input logic [2:0] k);
    logic [11:0] odd;
    logic [23:0] s;
    odd = {k, b};
    for (int i = 0; i < 12; i++) begin
      s[2*i+1] = odd[i];
      s[2*i]   = ~odd[i];
    end
    return s;
  endfunction

  task automatic run(input logic [23:0] st_ecc, input logic [23:0] ca_ecc,
                     input logic ign, input logic fx,
                     input logic [1:0] es, input logic [8:0] eb, input logic [2:0] ek,
                     input string req);
    exp_t e;
    @(negedge clk);
    stored_ecc_i = st_ecc; calc_ecc_i = ca_ecc;
    ignore_blank_i = ign; fix_en_i = fx; start_i = 1'b1;
    e.st = es; e.byt = eb; e.bt = ek; e.cyc = cyc; e.req = req;
    start_cyc = cyc;
    sb.push_back(e);
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic no_access(input int rd0, input int wr0, input string req);
    check(n_rd == rd0 && n_wr == wr0, req, "buffer touched", n_rd + n_wr, rd0 + wr0);
  endtask

  task automatic fix_case(input logic [8:0] b, input logic [2:0] k, input logic [7:0] init);
    logic [7:0] nb_lo, nb_hi;
    int rd0, wr0, d0;
    logic [23:0] stv;
    mem[b] = init;
    nb_lo = mem[(b - 9'd1) & 9'h1FF];
    nb_hi = mem[(b + 9'd1) & 9'h1FF];
    rd0 = n_rd; wr0 = n_wr; d0 = n_done;
    stv = 24'h5A3C96 ^ {15'd0, b};
    run(stv, stv ^ mk_syn(b, k), 1'b1, 1'b1, 2'd1, b, k, "R3");
    check(n_rd == rd0 + 1 && n_wr == wr0 + 1, "R8", "rmw count", n_rd + n_wr, rd0 + wr0 + 2);
    check(rd_cyc - start_cyc == 2, "R8", "read latency", rd_cyc - start_cyc, 2);
    check(wr_cyc - start_cyc == 3, "R8", "write latency", wr_cyc - start_cyc, 3);
    check(mem[b] == (init ^ (8'd1 << k)), "R8", "repaired byte", mem[b], init ^ (8'd1 << k));
    check(mem[(b - 9'd1) & 9'h1FF] == nb_lo && mem[(b + 9'd1) & 9'h1FF] == nb_hi,
          "R8", "neighbour bytes", mem[(b + 9'd1) & 9'h1FF], nb_hi);
    check(n_done == d0 + 1 && done_cyc - start_cyc == 4, "R9", "done timing",
          done_cyc - start_cyc, 4);
  endtask

  initial begin : watchdog
    #500000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int rd0, wr0;
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!result_valid_o && !mem_rd_o && !mem_wr_o && !fix_done_o && status_o == 2'd0,
          "R11", "reset outputs", {result_valid_o, mem_rd_o, mem_wr_o, fix_done_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 clean
    run(24'hC0FFEE, 24'hC0FFEE, 1'b0, 1'b1, 2'd0, 9'd0, 3'd0, "R1");
    // R2 blank with ignore
    rd0 = n_rd; wr0 = n_wr;
    run(24'hFFFFFF, 24'h123456, 1'b1, 1'b1, 2'd0, 9'd0, 3'd0, "R2");
    no_access(rd0, wr0, "R2");
    // R2 blank without ignore, repairable, fix off (R10)
    rd0 = n_rd; wr0 = n_wr;
    run(24'hFFFFFF, 24'hFFFFFF ^ mk_syn(9'd5, 3'd3), 1'b0, 1'b0, 2'd1, 9'd5, 3'd3, "R2");
    no_access(rd0, wr0, "R10");
    // R4 R5 index mapping across patterns, fix off
    run(24'h010203, 24'h010203 ^ mk_syn(9'h155, 3'd5), 1'b0, 1'b0, 2'd1, 9'h155, 3'd5, "R5");
    run(24'h000000, mk_syn(9'h0AA, 3'd2), 1'b0, 1'b0, 2'd1, 9'h0AA, 3'd2, "R4");
    // R8 R9 repair cases
    fix_case(9'h1A5, 3'd6, 8'h3C);
    fix_case(9'd0,   3'd0, 8'hFF);
    fix_case(9'd511, 3'd7, 8'h00);
    // R6 single-bit syndrome
    rd0 = n_rd; wr0 = n_wr;
    run(24'h777777, 24'h777776, 1'b1, 1'b1, 2'd2, 9'd0, 3'd0, "R6");
    run(24'h800000, 24'h000000, 1'b1, 1'b1, 2'd2, 9'd0, 3'd0, "R12");
    no_access(rd0, wr0, "R6");
    // R7 uncorrectable
    rd0 = n_rd; wr0 = n_wr;
    run(24'h000000, 24'h000003, 1'b0, 1'b1, 2'd3, 9'd0, 3'd0, "R7");
    run(24'hABCDEF, 24'hABCDEF ^ 24'h55AA00, 1'b0, 1'b1, 2'd3, 9'd0, 3'd0, "R7");
    no_access(rd0, wr0, "R7");
    // R1 all results consumed, no extra strobes
    check(sb.size() == 0, "R1", "pending results", sb.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule